// File: doc/BRIEF.md
# Double-Buffered Match Event Timer

This block is a free-running 10-bit up-counter. It advances once for every `2*(N+1)` system clock cycles, where `N` is an 8-bit prescale setting. A live compare register is fed from a second, staged compare register. When the counter steps onto the live compare value, the block raises a one-cycle event. At that same clock edge, the live compare register takes the staged value, so the next event can be programmed well ahead of time. Two events can therefore be as close as one count apart.

Each event also copies a software-prepared data word onto a parallel output bus. Output edges therefore land on exact counter values, however late software refills the staging registers. Each event sets a sticky flag, which software clears by writing a one. The interrupt output is the flag gated by an enable bit. The live count is always visible on an output, so software can timestamp external edges.

Top module: `match_event_timer`

## Requirements
- R1: While reset is held, `count_o`, `pout_o`, `match_evt_o`, `flag_o` and `irq_o` are all zero. The live compare value and the staged compare value both reset to 0.
- R2: Writing select 0 loads `N` from data bits [7:0]. From then on, `count_o` increments by one every `2*(N+1)` clock cycles, so the divisors run from 1 to 256 applied to clk/2.
- R3: The counter wraps from 1023 to 0. Passing through 0 raises an event only when the live compare value is 0.
- R4: `match_evt_o` is high for exactly one cycle: the first cycle in which `count_o` equals the live compare value.
- R5: At every event, the live compare value is replaced by the staged compare value (written with select 1, data bits [9:0]). A staged value one above the current compare value therefore yields a second event exactly one count later.
- R6: A select-1 write captured at the clock edge that reloads the live compare value affects only the event after next. The reload takes the staged value held before that write.
- R7: `pout_o` takes the staged output word (written with select 2, data bits [7:0]) in the cycle after `match_evt_o` is high. Writes to the staged word never change `pout_o` on their own.
- R8: `flag_o` becomes 1 in the cycle after `match_evt_o`. A select-3 write with data bit 1 set clears it. When that clear and an event's set land on the same edge, the set wins.
- R9: A select-3 write stores data bit 0 as the interrupt enable. `irq_o` is high exactly when `flag_o` and the enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 prescale, 1 staged compare, 2 staged output, 3 control |
| wr_data_i | input | 10 | Write data |
| count_o | output | 10 | Live counter value |
| match_evt_o | output | 1 | One-cycle compare event |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request (flag and enable) |
| pout_o | output | 8 | Parallel output register |

## Verification
Two pairs of actions can land on the same clock edge. The first pair is a staged-compare write and the live-compare reload. The second pair is a flag clear and the flag set from an event.

The bench runs with a divisor of 4, so each count lasts 8 cycles. It watches for the count just before the target value, then counts clock edges so that its write is captured on exactly the reload edge, or on the edge after the event.

The collisions are judged from later behaviour. For the first, the next event must occur at the old staged value and the one after it at the newly written value. For the second, the flag must still read 1 after the clear.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    typedef enum logic [1:0] {
        SEL_PRESCALE = 2'd0,
        SEL_NEXT_CMP = 2'd1,
        SEL_STAGE    = 2'd2,
        SEL_CTRL     = 2'd3
    } wr_sel_e;

    localparam int CTRL_IEN_BIT = 0;
    localparam int CTRL_CLR_BIT = 1;

endpackage

// File: rtl/mtmr_prescaler.sv
module mtmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             div_we_i,
    input  logic [PRE_W-1:0] div_val_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] div;
        logic [PRE_W-1:0] cnt;
        logic             half;
        logic             tick;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        st_d.half = ~st_q.half;
        if (div_we_i) begin
            st_d.div = div_val_i;
        end
        if (st_q.half) begin
            if (st_q.cnt >= st_q.div) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    AST_TICK_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.tick |=> !st_q.tick); // R2

    AST_TICK_ON_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.tick) |-> $past(st_q.half)); // R2

endmodule

// File: rtl/mtmr_compare.sv
module mtmr_compare #(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             next_we_i,
    input  logic [CNT_W-1:0] next_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             evt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] live;
        logic [CNT_W-1:0] nxt;
        logic             evt;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (next_we_i) begin
            st_d.nxt = next_val_i;
        end
        if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == st_q.live) begin
                st_d.evt  = 1'b1;
                st_d.live = st_q.nxt;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign evt_o   = st_q.evt;

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.cnt) |-> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1))); // R3

    AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.evt |=> !st_q.evt); // R4

    AST_EVT_AT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.evt |-> (st_q.cnt == $past(st_q.live))); // R4

    AST_LIVE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.evt |-> (st_q.live == $past(st_q.nxt))); // R5

    AST_LIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.evt |-> $stable(st_q.live)); // R6

endmodule

// File: rtl/mtmr_out_stage.sv
module mtmr_out_stage #(
    parameter int OUT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             evt_i,
    input  logic             stage_we_i,
    input  logic [OUT_W-1:0] stage_val_i,
    input  logic             ctrl_we_i,
    input  logic             ien_val_i,
    input  logic             clr_val_i,
    output logic [OUT_W-1:0] pout_o,
    output logic             flag_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [OUT_W-1:0] stage;
        logic [OUT_W-1:0] pout;
        logic             ien;
        logic             flag;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stage_we_i) begin
            st_d.stage = stage_val_i;
        end
        if (ctrl_we_i) begin
            st_d.ien = ien_val_i;
            if (clr_val_i) begin
                st_d.flag = 1'b0;
            end
        end
        if (evt_i) begin
            st_d.pout = st_q.stage;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pout_o = st_q.pout;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & st_q.ien;

    AST_POUT_ONLY_ON_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.pout) |-> $past(evt_i)); // R7

    AST_FLAG_SET_ON_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i |=> st_q.flag); // R8

    AST_FLAG_CLR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.flag) |-> $past(ctrl_we_i && clr_val_i)); // R8

endmodule

// File: rtl/match_event_timer.sv
module match_event_timer
    import mtmr_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int PRE_W = 8,
    parameter int OUT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             match_evt_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic [OUT_W-1:0] pout_o
);

    wr_sel_e sel;
    logic    we_pre, we_next, we_stage, we_ctrl;
    logic    tick;

    always_comb begin
        sel      = wr_sel_e'(wr_sel_i);
        we_pre   = wr_en_i && (sel == SEL_PRESCALE);
        we_next  = wr_en_i && (sel == SEL_NEXT_CMP);
        we_stage = wr_en_i && (sel == SEL_STAGE);
        we_ctrl  = wr_en_i && (sel == SEL_CTRL);
    end

    mtmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_we_i  (we_pre),
        .div_val_i (wr_data_i[PRE_W-1:0]),
        .tick_o    (tick)
    );

    mtmr_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .next_we_i  (we_next),
        .next_val_i (wr_data_i),
        .count_o    (count_o),
        .evt_o      (match_evt_o)
    );

    mtmr_out_stage #(.OUT_W(OUT_W)) u_out (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .evt_i       (match_evt_o),
        .stage_we_i  (we_stage),
        .stage_val_i (wr_data_i[OUT_W-1:0]),
        .ctrl_we_i   (we_ctrl),
        .ien_val_i   (wr_data_i[CTRL_IEN_BIT]),
        .clr_val_i   (wr_data_i[CTRL_CLR_BIT]),
        .pout_o      (pout_o),
        .flag_o      (flag_o),
        .irq_o       (irq_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |=> (count_o == '0 && !match_evt_o && !flag_o && pout_o == '0)); // R1

endmodule

// File: tb/match_event_timer_tb.sv
module match_event_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    // {event count value, output word expected after that event}
    localparam logic [17:0] VEC [NV] = '{
        {10'd0,    8'h11},
        {10'd7,    8'hA5},
        {10'd8,    8'h5A},
        {10'd100,  8'h0F},
        {10'd1023, 8'hF0},
        {10'd3,    8'h3C},
        {10'd4,    8'hC3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [9:0] wr_data = '0;
    logic [9:0] count;
    logic       evt, flag, irq;
    logic [7:0] pout;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    match_event_timer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (wr_en),
        .wr_sel_i    (wr_sel),
        .wr_data_i   (wr_data),
        .count_o     (count),
        .match_evt_o (evt),
        .flag_o      (flag),
        .irq_o       (irq),
        .pout_o      (pout)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [9:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_evt(input string req);
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!evt && k < 20000);
        if (!evt) chk(req, 0, 1);
    endtask

    task automatic wait_count(input logic [9:0] v);
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (count != v && k < 20000);
    endtask

    task automatic period(output int n);
        logic [9:0] c0;
        int k = 0;
        @(negedge clk);
        c0 = count;
        while (count == c0 && k < 1000) begin @(negedge clk); k++; end
        c0 = count;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (count == c0 && n < 1000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 count", count, 0);
        chk("R1 pout", pout, 0);
        chk("R1 evt", evt, 0);
        chk("R1 flag", flag, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1'b1;

        // R2: divisor 4 -> 8 cycles per count
        wr(2'd0, 10'd3);
        period(n);
        chk("R2 period N=3", n, 8);

        wr(2'd1, VEC[1][17:8]);
        wr(2'd2, 10'(VEC[0][7:0]));
        wr(2'd3, 10'b01);
        chk("R7 stage write leaves pout", pout, 0);

        // table walk: event count, output word, flag, irq (R3 R4 R5 R7 R8 R9)
        for (int j = 0; j < NV; j++) begin
            logic [9:0] nx;
            wait_evt("R4 event missing");
            chk("R4 R3 R5 event count", count, int'(VEC[j][17:8]));
            @(negedge clk);
            chk("R4 evt one cycle", evt, 0);
            chk("R7 pout after event", pout, int'(VEC[j][7:0]));
            chk("R8 flag set", flag, 1);
            chk("R9 irq enabled", irq, 1);
            if (j + 2 < NV) nx = VEC[j+2][17:8];
            else if (j == NV - 2) nx = 10'd600;
            else nx = 10'd650;
            wr(2'd1, nx);
            if (j + 1 < NV) wr(2'd2, 10'(VEC[j+1][7:0]));
        end

        // R9: enable gates irq, flag kept
        wr(2'd3, 10'b00);
        chk("R9 irq disabled", irq, 0);
        chk("R9 flag kept", flag, 1);
        wr(2'd3, 10'b01);
        chk("R9 irq reenabled", irq, 1);
        // R8: write-one clear
        wr(2'd3, 10'b11);
        chk("R8 clear flag", flag, 0);
        chk("R9 irq after clear", irq, 0);

        // R6: staged compare write on reload edge (live 600, staged 650)
        wait_count(10'd599);
        repeat (7) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 10'd700;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 collision event", evt, 1);
        chk("R6 collision count", count, 600);
        wait_evt("R6 event missing");
        chk("R6 old staged used", count, 650);
        @(negedge clk);
        wr(2'd3, 10'b11);
        chk("R8 cleared before collision", flag, 0);

        // R8: clear captured on the edge that sets the flag
        wait_count(10'd699);
        repeat (8) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 10'b11;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 set wins over clear", flag, 1);
        chk("R6 new staged used", count, 700);

        // R2: extreme divisors
        wr(2'd0, 10'd0);
        period(n);
        chk("R2 period N=0", n, 2);
        wr(2'd0, 10'd255);
        period(n);
        chk("R2 period N=255", n, 512);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule